// File: doc/BRIEF.md
# MIR Receive Deframer and Checker

This block takes a medium-rate infrared bit stream that has already been sampled at the bit rate. It receives one bit for each strobe of `bit_en`. It hunts for the flag octet (bit pattern 0,1,1,1,1,1,1,0), skips any run of opening flags, and drops the zero that the sender inserts after five consecutive ones. It packs the remaining bits into bytes, least significant bit first. The last two received bytes are the frame check sequence and are never passed on. When the closing flag arrives, the block raises a one-cycle end-of-frame pulse and loads a three-bit status word for the host to read.

The block runs a control machine with three states. HUNT waits for a flag. OPEN has seen a flag but no payload bit yet. RECV is collecting a frame. The transitions are:

- HUNT to OPEN on a flag.
- OPEN to OPEN on a further flag.
- OPEN to RECV when the first payload bit leaves the flag-stripping window.
- OPEN to HUNT on an abort.
- RECV to OPEN on the closing flag, which reports status. The closing flag may also open the next frame.
- RECV to HUNT on an abort, which reports abort status.
- Any state to HUNT while reception is blocked.

Reception is blocked whenever `rx_disable` or `tx_active` is high.

Top module: `mir_rx_deframer`

## Requirements
- R1: Before the first flag, nothing is output. Any number of consecutive opening flags is removed, and the payload starts at the first bit that does not belong to a flag. A run of idle ones outside a frame produces no output and no status.
- R2: A 0 bit received after exactly five consecutive 1 bits is dropped from the data.
- R3: Processing the final bit of a closing flag while in RECV gives `frame_end` high for exactly one cycle, on the cycle after that strobe. A single flag between two frames both closes the first frame and opens the second.
- R4: The last two bytes of each frame are withheld. Every earlier byte appears on `byte_data` with a one-cycle `byte_valid`. Each byte is assembled with the first received bit in bit 0.
- R5: A CRC is run over all payload and check bits. It uses the reflected CRC-16 polynomial 0x8408, the register starts at 0xFFFF, and bits are taken in arrival order. If the final value is not 0xF0B8, status bit 1 (crc error) is set at end of frame.
- R6: Seven consecutive 1 bits in RECV end the frame with `frame_end`, with status 3'b001 (bit 0 is abort, the other bits are clear). The block then returns to HUNT and needs a new flag. Bytes not yet output are discarded.
- R7: Status bit 2 (length error) is set at end of frame in any of these cases: the number of destuffed bits is not a multiple of eight, the frame has fewer than two bytes, or the payload byte count (all bytes minus two) exceeds `max_len`.
- R8: `rx_stat` is 0 after reset and changes only on a cycle where `frame_end` is high.
- R9: While `rx_disable` or `tx_active` is high, strobes are ignored and any partial frame is dropped without `frame_end`. Reception resumes only after a new flag.
- R10: `byte_valid` and `frame_end` never occur in the same cycle, and each occurs only on the cycle after an accepted `bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Strobe: `bit_in` is valid this cycle |
| bit_in | input | 1 | Sampled line bit |
| rx_disable | input | 1 | Host receive disable |
| tx_active | input | 1 | Local transmitter busy, which blocks reception |
| max_len | input | LEN_W | Largest allowed payload byte count |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Payload byte |
| frame_end | output | 1 | One-cycle end-of-frame pulse |
| rx_stat | output | 3 | Status: bit 0 abort, bit 1 crc error, bit 2 length error |

## Verification
The hardest situation to reach is a frame that is cut off by blocking partway through and then followed by a closing flag. The closing flag must reopen the line without reporting a frame. The bench raises `rx_disable` after two bytes have already gone into the hold buffer and keeps sending the rest of the frame. It then drops the disable before the closing flag and checks that no byte, pulse or status change appears. Odd-length frames are built by inserting a few raw data bits between the check bytes and the flag, so the bit count is not a multiple of eight while the stuffing stays valid.

// File: rtl/mir_rx_pkg.sv
package mir_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_OPEN = 2'd1,
        ST_RECV = 2'd2
    } rx_state_t;

    localparam logic [15:0] CRC_INIT     = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;

    localparam int STAT_W    = 3;
    localparam int STAT_ABT  = 0;
    localparam int STAT_CRC  = 1;
    localparam int STAT_LEN  = 2;
    localparam int FCS_BYTES = 2;

endpackage

// File: rtl/mir_rx_unstuff.sv
module mir_rx_unstuff #(
    parameter int FLAG_ONES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic din,
    output logic flag_ev,
    output logic abort_ev,
    output logic commit_v,
    output logic commit_bit
);
    localparam int STUFF_ONES = FLAG_ONES - 1;
    localparam int ABORT_ONES = FLAG_ONES + 1;
    localparam int WIN        = FLAG_ONES + 1;
    localparam int ONES_W     = $clog2(ABORT_ONES + 1);
    localparam int FILL_W     = $clog2(WIN + 1);

    logic [ONES_W-1:0] ones;
    logic [WIN-1:0]    win;
    logic [FILL_W-1:0] fill;
    logic              stuffed;
    logic              push;

    always_comb begin
        stuffed    = step && !din && (ones == ONES_W'(STUFF_ONES));
        flag_ev    = step && !din && (ones == ONES_W'(FLAG_ONES));
        abort_ev   = step &&  din && (ones == ONES_W'(FLAG_ONES));
        push       = step && !stuffed && !flag_ev &&
                     (!din || (ones < ONES_W'(FLAG_ONES)));
        commit_v   = push && (fill == FILL_W'(WIN));
        commit_bit = win[WIN-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ones <= '0;
            win  <= '0;
            fill <= '0;
        end else if (step) begin
            if (din) begin
                if (ones != ONES_W'(ABORT_ONES))
                    ones <= ones + 1'b1;
            end else begin
                ones <= '0;
            end
            if (flag_ev || abort_ev) begin
                fill <= '0;
            end else if (push) begin
                win <= {win[WIN-2:0], din};
                if (fill != FILL_W'(WIN))
                    fill <= fill + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mir_rx_crc16.sv
module mir_rx_crc16 #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h8408,
    parameter logic [15:0] INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;

    always_comb fb = crc[0] ^ din;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            crc <= INIT[CRC_W-1:0];
        else if (step)
            crc <= (crc >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
    end
endmodule

// File: rtl/mir_rx_bytepack.sv
module mir_rx_bytepack #(
    parameter int DATA_W = 8,
    parameter int HOLD   = 2,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              din,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [$clog2(DATA_W)-1:0] phase,
    output logic [CNT_W-1:0]  total
);
    localparam int PH_W = $clog2(DATA_W);
    localparam int HC_W = $clog2(HOLD + 1);

    logic [DATA_W-1:0]      sh;
    logic [DATA_W-1:0]      new_byte;
    logic [HOLD*DATA_W-1:0] hold;
    logic [HC_W-1:0]        hcnt;
    logic                   byte_done;

    always_comb begin
        new_byte  = {din, sh[DATA_W-1:1]};
        byte_done = step && (phase == PH_W'(DATA_W - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            phase     <= '0;
            hold      <= '0;
            hcnt      <= '0;
            total     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (clear) begin
                phase <= '0;
                hcnt  <= '0;
                total <= '0;
            end else if (step) begin
                sh    <= new_byte;
                phase <= byte_done ? '0 : phase + 1'b1;
                if (byte_done) begin
                    if (total != '1)
                        total <= total + 1'b1;
                    hold <= {new_byte, hold[HOLD*DATA_W-1:DATA_W]};
                    if (hcnt == HC_W'(HOLD)) begin
                        out_valid <= 1'b1;
                        out_data  <= hold[DATA_W-1:0];
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mir_rx_deframer.sv
module mir_rx_deframer
    import mir_rx_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int FLAG_ONES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             rx_disable,
    input  logic             tx_active,
    input  logic [LEN_W-1:0] max_len,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             frame_end,
    output logic [2:0]       rx_stat
);
    localparam int DATA_W = 8;
    localparam int TOT_W  = LEN_W + 1;
    localparam int PH_W   = $clog2(DATA_W);

    rx_state_t        state, state_nx;
    logic             blocked, step;
    logic             flag_ev, abort_ev, commit_v, commit_bit;
    logic             pk_step, pk_clear;
    logic [15:0]      crc;
    logic [PH_W-1:0]  phase;
    logic [TOT_W-1:0] total;
    logic [TOT_W-1:0] payload;
    logic             len_err, crc_err;

    always_comb begin
        blocked  = rx_disable || tx_active;
        step     = bit_en && !blocked;
        pk_step  = commit_v && (state != ST_HUNT);
        pk_clear = blocked || flag_ev || abort_ev;
        payload  = total - TOT_W'(FCS_BYTES);
        len_err  = (phase != '0) || (total < TOT_W'(FCS_BYTES)) ||
                   (payload > {1'b0, max_len});
        crc_err  = (crc != CRC_RESIDUE);
    end

    mir_rx_unstuff #(.FLAG_ONES(FLAG_ONES)) u_unstuff (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (blocked),
        .step       (step),
        .din        (bit_in),
        .flag_ev    (flag_ev),
        .abort_ev   (abort_ev),
        .commit_v   (commit_v),
        .commit_bit (commit_bit)
    );

    mir_rx_crc16 #(.CRC_W(16), .POLY(CRC_POLY_REV), .INIT(CRC_INIT)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pk_clear),
        .step  (pk_step),
        .din   (commit_bit),
        .crc   (crc)
    );

    mir_rx_bytepack #(.DATA_W(DATA_W), .HOLD(FCS_BYTES), .CNT_W(TOT_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pk_clear),
        .step      (pk_step),
        .din       (commit_bit),
        .out_valid (byte_valid),
        .out_data  (byte_data),
        .phase     (phase),
        .total     (total)
    );

    always_comb begin
        state_nx = state;
        if (blocked) begin
            state_nx = ST_HUNT;
        end else begin
            unique case (state)
                ST_HUNT: if (flag_ev) state_nx = ST_OPEN;
                ST_OPEN: begin
                    if (abort_ev)      state_nx = ST_HUNT;
                    else if (commit_v) state_nx = ST_RECV;
                end
                ST_RECV: begin
                    if (abort_ev)     state_nx = ST_HUNT;
                    else if (flag_ev) state_nx = ST_OPEN;
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_end <= 1'b0;
            rx_stat   <= '0;
        end else begin
            frame_end <= 1'b0;
            if (!blocked && state == ST_RECV) begin
                if (abort_ev) begin
                    frame_end         <= 1'b1;
                    rx_stat           <= '0;
                    rx_stat[STAT_ABT] <= 1'b1;
                end else if (flag_ev) begin
                    frame_end         <= 1'b1;
                    rx_stat[STAT_ABT] <= 1'b0;
                    rx_stat[STAT_CRC] <= crc_err;
                    rx_stat[STAT_LEN] <= len_err;
                end
            end
        end
    end
endmodule

// File: rtl/mir_rx_deframer_chk.sv
module mir_rx_deframer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       rx_disable,
    input logic       tx_active,
    input logic       byte_valid,
    input logic       frame_end,
    input logic [2:0] rx_stat
);
    a_r10_no_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && frame_end));

    a_r10_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid || frame_end) |-> $past(bit_en));

    a_r9_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_disable || tx_active) |-> (!byte_valid && !frame_end));

    a_r8_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |-> $stable(rx_stat));

    a_r6_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stat[0] |-> (rx_stat[2:1] == 2'b00));
endmodule

bind mir_rx_deframer mir_rx_deframer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .rx_disable (rx_disable),
    .tx_active  (tx_active),
    .byte_valid (byte_valid),
    .frame_end  (frame_end),
    .rx_stat    (rx_stat)
);

// File: tb/mir_rx_deframer_test.sv
module mir_rx_deframer_test;
    logic        clk = 1'b0;
    logic        rst_n, bit_en, bit_in, rx_disable, tx_active;
    logic [11:0] max_len;
    logic        byte_valid, frame_end;
    logic [7:0]  byte_data;
    logic [2:0]  rx_stat;

    always #10 clk = ~clk;

    mir_rx_deframer uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .rx_disable(rx_disable), .tx_active(tx_active), .max_len(max_len),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_end(frame_end), .rx_stat(rx_stat)
    );

    int         n_chk = 0, n_fail = 0, n_frames = 0, tx_ones = 0;
    logic [2:0] last_stat = '0;
    logic [7:0] rx_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] exp_q[$];

    always @(negedge clk) if (rst_n) begin
        if (byte_valid) rx_q.push_back(byte_data);
        if (frame_end) begin
            n_frames++;
            last_stat = rx_stat;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_data_bit(input logic b);
        send_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        return (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
    endfunction

    task automatic send_body(input bit bad);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        foreach (tx_q[k]) begin
            send_byte(tx_q[k]);
            for (int i = 0; i < 8; i++) c = crc_bit(c, tx_q[k][i]);
        end
        fcs = ~c;
        if (bad) fcs = fcs ^ 16'h0001;
        send_byte(fcs[7:0]);
        send_byte(fcs[15:8]);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_payload(input string tag);
        chk({tag, " byte count"}, rx_q.size(), exp_q.size());
        foreach (exp_q[k])
            if (k < rx_q.size()) chk({tag, " byte"}, rx_q[k], exp_q[k]);
    endtask

    task automatic t_reset();
        chk("R8 reset stat", rx_stat, 0);
        chk("R10 reset byte_valid", byte_valid, 0);
        chk("R3 reset frame_end", frame_end, 0);
    endtask

    task automatic t_good();
        int f0;
        rx_q.delete(); exp_q.delete();
        f0 = n_frames;
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        settle();
        chk("R1 idle ones no output", rx_q.size() + n_frames - f0, 0);
        tx_q = '{8'hFF, 8'h7E, 8'h3E, 8'hF8, 8'h00, 8'hA5};
        exp_q = tx_q;
        send_flag(); send_flag(); send_flag();
        send_body(1'b0);
        send_flag();
        settle();
        chk("R3 one frame_end", n_frames - f0, 1);
        chk("R5 good crc stat", last_stat, 0);
        chk_payload("R1 R2 R4 stuffed payload");
    endtask

    task automatic t_crc();
        rx_q.delete();
        tx_q = '{8'h11, 8'h22, 8'h33};
        exp_q = tx_q;
        send_flag();
        send_body(1'b1);
        send_flag();
        settle();
        chk("R5 crc error stat", last_stat, 3'b010);
        chk_payload("R4 payload on crc error");
        for (int i = 0; i < 20; i++) send_bit(1'b1);
        settle();
        chk("R8 stat held over idle", rx_stat, 3'b010);
    endtask

    task automatic t_abort();
        int f0;
        rx_q.delete();
        f0 = n_frames;
        send_flag();
        send_byte(8'h12); send_byte(8'h34);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        settle();
        chk("R6 abort frame_end", n_frames - f0, 1);
        chk("R6 abort stat", last_stat, 3'b001);
        chk("R6 held bytes dropped", rx_q.size(), 0);
        tx_q = '{8'h5A, 8'hC3};
        exp_q = tx_q;
        send_flag(); send_body(1'b0); send_flag();
        settle();
        chk("R6 recovery stat", last_stat, 0);
        chk_payload("R6 recovery payload");
    endtask

    task automatic t_len();
        max_len = 12'd4;
        tx_q = '{8'h01, 8'h02, 8'h03, 8'h04};
        send_flag(); send_body(1'b0); send_flag(); settle();
        chk("R7 payload at max ok", last_stat, 0);
        tx_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        send_flag(); send_body(1'b0); send_flag(); settle();
        chk("R7 payload over max", last_stat, 3'b100);
        max_len = 12'd16;
        tx_q = '{8'h0F, 8'hF0, 8'h99};
        send_flag(); send_body(1'b0);
        send_data_bit(1'b0); send_data_bit(1'b1); send_data_bit(1'b0);
        send_flag(); settle();
        chk("R7 odd bit count", last_stat[2], 1);
        chk("R7 odd bit count not abort", last_stat[0], 0);
        send_flag(); send_byte(8'h55); send_flag(); settle();
        chk("R7 single byte frame", last_stat[2], 1);
    endtask

    task automatic t_block();
        int f0;
        logic [2:0] s0;
        rx_q.delete();
        f0 = n_frames;
        s0 = rx_stat;
        send_flag();
        send_byte(8'hAA); send_byte(8'hBB);
        @(negedge clk); rx_disable = 1'b1;
        send_byte(8'hCC); send_byte(8'hDD);
        @(negedge clk); rx_disable = 1'b0;
        send_byte(8'hEE); send_byte(8'h12); send_byte(8'h34);
        send_flag(); settle();
        chk("R9 disable no frame_end", n_frames - f0, 0);
        chk("R9 disable no bytes", rx_q.size(), 0);
        chk("R8 stat unchanged", rx_stat, s0);
        @(negedge clk); tx_active = 1'b1;
        tx_q = '{8'h44, 8'h55, 8'h66};
        send_flag(); send_body(1'b0); send_flag();
        @(negedge clk); tx_active = 1'b0;
        settle();
        chk("R9 tx_active ignored", rx_q.size() + n_frames - f0, 0);
        exp_q = tx_q;
        send_flag(); send_body(1'b0); send_flag(); settle();
        chk("R9 resume after flag", n_frames - f0, 1);
        chk_payload("R9 resume payload");
    endtask

    task automatic t_b2b();
        int f0;
        rx_q.delete(); exp_q.delete();
        f0 = n_frames;
        send_flag();
        tx_q = '{8'hDE, 8'hAD};
        foreach (tx_q[k]) exp_q.push_back(tx_q[k]);
        send_body(1'b0);
        send_flag();
        tx_q = '{8'hBE, 8'hEF, 8'h1F};
        foreach (tx_q[k]) exp_q.push_back(tx_q[k]);
        send_body(1'b0);
        send_flag();
        settle();
        chk("R3 shared flag two frames", n_frames - f0, 2);
        chk("R5 second frame stat", last_stat, 0);
        chk_payload("R3 shared flag payload");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b1;
        rx_disable = 1'b0; tx_active = 1'b0; max_len = 12'd16;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_crc();
        t_abort();
        t_len();
        t_block();
        t_b2b();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule